// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block keeps the bookkeeping for a windowed register file with eight windows. It holds the current window pointer and two counters. One counts the windows a save can still claim. The other counts the caller windows still resident, which a restore can return to. Save and restore (or return) requests arrive one at a time.

When a save finds no free window, the block asks an outside agent to spill the current window to memory. When a restore finds no resident caller, the block asks for a fill of the current window. Each of these requests names the window index. The block then waits for a done pulse, and the pointer and counters change only in the cycle that done is seen. Requests that need no memory traffic complete in a single cycle.

The register storage, the memory transfers and any trap delivery sit outside this block.

Top module: `win_occ_ctrl`

## Requirements
- R1: After reset the pointer is 0, the saveable count is 6 and the restorable count is 0. Ready is high, and spill, fill and error are low.
- R2: A save accepted with a nonzero saveable count completes at the next edge. The pointer becomes (pointer+1) mod 8, the saveable count drops by one and the restorable count rises by one.
- R3: A save accepted with a zero saveable count raises spill_req, with xfer_win equal to the current pointer, at the next edge. Ready drops, and the pointer and counters hold until xfer_done is sampled.
- R4: At the edge where xfer_done is sampled during a spill, spill_req and busy clear. The pointer becomes (pointer+1) mod 8, the saveable count becomes the old restorable count minus one, and the restorable count becomes 1.
- R5: A restore accepted with a nonzero restorable count completes at the next edge. The pointer becomes (pointer+7) mod 8, the saveable count rises by one and the restorable count drops by one.
- R6: A restore accepted with a zero restorable count raises fill_req, with xfer_win equal to the current pointer. At the done edge the pointer becomes (pointer+7) mod 8, the restorable count stays 0, and the saveable count rises by one only if it is below 6.
- R7: While a spill or fill is outstanding, ready is low and new save or restore requests change nothing.
- R8: A save and a restore in the same accepted cycle raise err for exactly one cycle, and neither operation is performed.
- R9: The 5-bit pointer output always holds a value 0 to 7, so its upper two bits are zero, and it wraps (7 to 0 on save, 0 to 7 on restore).
- R10: The saveable and restorable counts always sum to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Save request, sampled when ready |
| rest_req | input | 1 | Restore/return request, sampled when ready |
| xfer_done | input | 1 | Spill or fill finished |
| ready | output | 1 | Idle and able to take a request |
| spill_req | output | 1 | Spill of xfer_win requested |
| fill_req | output | 1 | Fill of xfer_win requested |
| xfer_win | output | 3 | Window index to spill or fill |
| err | output | 1 | One-cycle pulse on a simultaneous save and restore |
| cur_win | output | 5 | Current window pointer |
| can_save | output | 3 | Saveable window count |
| can_rest | output | 3 | Restorable window count |

## Verification
The bench drives a request on one falling edge and samples on the next falling edge. There, a simple save or restore has already updated the pointer and counters, a spill or fill has raised its request, and a simultaneous request has raised err. For spill and fill it pulses done the same way, samples one half-cycle after the done edge, and checks that nothing moved in the cycles before that edge. Requests sent while busy are checked at the outputs before done arrives.

// File: rtl/win_occ_ctrl.sv
module win_occ_ctrl #(
  parameter int NWIN = 8,
  parameter int PW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_req,
  input  logic          rest_req,
  input  logic          xfer_done,
  output logic          ready,
  output logic          spill_req,
  output logic          fill_req,
  output logic [$clog2(NWIN)-1:0] xfer_win,
  output logic          err,
  output logic [PW-1:0] cur_win,
  output logic [$clog2(NWIN)-1:0] can_save,
  output logic [$clog2(NWIN)-1:0] can_rest
);
  localparam int CW = $clog2(NWIN);
  localparam logic [CW-1:0] LIMIT = CW'(NWIN - 2);

  logic [CW-1:0] cwp, cs, cr;
  logic busy, is_fill;

  assign ready     = !busy;
  assign spill_req = busy && !is_fill;
  assign fill_req  = busy && is_fill;
  assign xfer_win  = cwp;
  assign cur_win   = PW'(cwp);
  assign can_save  = cs;
  assign can_rest  = cr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp <= '0; cs <= LIMIT; cr <= '0;
      busy <= 1'b0; is_fill <= 1'b0; err <= 1'b0;
    end else begin
      err <= 1'b0;
      if (busy) begin
        if (xfer_done) begin
          busy <= 1'b0;
          if (is_fill) begin
            cwp <= cwp - 1'b1;
            if (cs < LIMIT) cs <= cs + 1'b1;
          end else begin
            cwp <= cwp + 1'b1;
            cs  <= cr - 1'b1;
            cr  <= CW'(1);
          end
        end
      end else if (save_req && rest_req) begin
        err <= 1'b1;
      end else if (save_req) begin
        if (cs == '0) begin
          busy <= 1'b1; is_fill <= 1'b0;
        end else begin
          cwp <= cwp + 1'b1; cs <= cs - 1'b1; cr <= cr + 1'b1;
        end
      end else if (rest_req) begin
        if (cr == '0) begin
          busy <= 1'b1; is_fill <= 1'b1;
        end else begin
          cwp <= cwp - 1'b1; cs <= cs + 1'b1; cr <= cr - 1'b1;
        end
      end
    end
  end

  a_r3_spill_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_req && !xfer_done) |=> (spill_req && $stable(cur_win) && $stable(can_save)));
  a_r7_busy_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $onehot0({spill_req, fill_req}) && (spill_req || fill_req));
  a_r8_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(cur_win) && $stable(can_save) && $stable(can_rest)));
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cur_win < PW'(NWIN));
  a_r10_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(can_save) + 32'(can_rest)) == NWIN - 2);
  a_r6_fill_rest_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> can_rest == '0);
endmodule

// File: tb/tb_win_occ_ctrl.sv
module tb_win_occ_ctrl;
  logic clk = 0, rst_n = 0, save_req = 0, rest_req = 0, xfer_done = 0;
  logic ready, spill_req, fill_req, err;
  logic [2:0] xfer_win, can_save, can_rest;
  logic [4:0] cur_win;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  win_occ_ctrl dut (.clk, .rst_n, .save_req, .rest_req, .xfer_done, .ready,
    .spill_req, .fill_req, .xfer_win, .err, .cur_win, .can_save, .can_rest);

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic st(string tag, int w, int s, int r);
    chk({tag, " win"}, cur_win, w);
    chk({tag, " can_save"}, can_save, s);
    chk({tag, " can_rest"}, can_rest, r);
  endtask

  task automatic req(bit s, bit r);
    @(negedge clk); save_req = s; rest_req = r;
    @(negedge clk); save_req = 0; rest_req = 0;
  endtask

  task automatic done();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  task automatic t_reset();
    st("R1 reset", 0, 6, 0);
    chk("R1 ready", ready, 1);
    chk("R1 spill/fill/err", {spill_req, fill_req, err}, 0);
  endtask

  task automatic t_fill_wrap();
    req(0, 1);
    chk("R6 fill_req", fill_req, 1);
    chk("R6 xfer_win", xfer_win, 0);
    chk("R7 ready low", ready, 0);
    @(negedge clk);
    st("R6 hold before done", 0, 6, 0);
    done();
    chk("R6 fill clear", fill_req, 0);
    st("R6 R9 after fill wrap", 7, 6, 0);
  endtask

  task automatic t_saves();
    req(1, 0);
    st("R2 R9 save wrap", 0, 5, 1);
    for (int k = 1; k <= 5; k++) begin
      req(1, 0);
      st("R2 save", k, 5 - k, 1 + k);
    end
  endtask

  task automatic t_spill();
    req(1, 0);
    chk("R3 spill_req", spill_req, 1);
    chk("R3 xfer_win", xfer_win, 5);
    st("R3 hold", 5, 0, 6);
    req(0, 1);
    st("R7 restore ignored", 5, 0, 6);
    chk("R7 still spilling", spill_req, 1);
    req(1, 0);
    st("R7 save ignored", 5, 0, 6);
    done();
    chk("R4 spill clear", spill_req, 0);
    chk("R4 ready", ready, 1);
    st("R4 after spill", 6, 5, 1);
  endtask

  task automatic t_restore();
    req(0, 1);
    st("R5 restore", 5, 6, 0);
    chk("R5 no fill", fill_req, 0);
  endtask

  task automatic t_both();
    req(1, 1);
    chk("R8 err", err, 1);
    st("R8 no change", 5, 6, 0);
    chk("R8 no fill", fill_req, 0);
    @(negedge clk);
    chk("R8 err one cycle", err, 0);
  endtask

  task automatic t_upper();
    chk("R9 upper bits", cur_win[4:3], 0);
    chk("R10 sum", can_save + can_rest, 6);
  endtask

  initial begin : wd
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_wrap();
    t_saves();
    t_spill();
    t_restore();
    t_both();
    t_upper();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule